// File: doc/BRIEF.md
# Puncture Rate and Phase Search Controller

This block steers the synchronisation of a punctured convolutional decoder. The decoder reports a strobe for each decoded bit and a flag when that bit was in error. The block counts errors over free-running windows of 2^WIN_LG bit strobes and publishes each window's count as an 8-bit error rate. At every window end it compares that rate with a 7-bit threshold chosen for the rate now under trial. It then keeps the current hypothesis, declares lock, or moves on to the next puncture phase and then the next enabled rate.

Two control bits select the mode. `mode_am_i`=0 with `mode_f_i`=0 is the full automatic search. `mode_am_i`=0 with `mode_f_i`=1 keeps the current rate fixed and cycles only its phases. `mode_am_i`=1 hands control to software: the rate is forced to the single enabled rate, and every rising edge of `mode_f_i` advances the phase. Once lock is held, a hysteresis margin on top of the threshold keeps a short burst of errors from dropping it. A time-out, counted in windows, moves the search on when the error rate is low but block sync does not appear.

Top module: `punct_search`

## Requirements
- R1: Errors are counted only in cycles where `bit_stb_i` is high. After every 2^WIN_LG bit strobes, `err_rate_o` takes that window's error count, saturated at 255. Between window ends it holds its value.
- R2: After reset, `rate_o`=0, `phase_o`=0, `lock_o`=0 and `err_rate_o`=0.
- R3: In automatic mode, while unlocked, a window whose error rate is greater than the threshold of the current rate advances the phase. After the last phase, the phase returns to 0 and the rate moves to the next enabled rate index, wrapping from 4 back to 0. Outside of window ends, rate and phase hold.
- R4: Rate index 0..4 encodes 1/2, 2/3, 3/4, 5/6, and 7/8 (with `std_alt_i`=0) or 6/7 (with `std_alt_i`=1). The phase counts are 1, 2, 3, 5 and 7 or 6. The threshold for rate k is `thr_i[7k+6:7k]`.
- R5: At a window end in automatic or frozen mode, if the current rate is not enabled in `rate_en_i` (bit k is rate k), the rate jumps to the next enabled index, phase 0, and lock drops.
- R6: While unlocked, when the error rate is at or below the threshold but `sync_i` is low at a window end, the search steps as in R3 on the `timeout_i`-th such consecutive window. A value of 0 acts as 1.
- R7: Lock is set at a window end when the error rate is at or below the threshold and `sync_i` is high.
- R8: While locked, lock holds at each window end while the error rate is at most threshold plus `hyst_i` and `sync_i` is high. Otherwise lock drops, with no change of rate or phase.
- R9: In frozen mode (`mode_am_i`=0, `mode_f_i`=1), a step wraps the phase within the current rate and never changes the rate.
- R10: In manual mode (`mode_am_i`=1), the rate is forced to the lowest enabled index. The phase is kept, or cleared if it is out of range for that rate. Each rising edge of `mode_f_i` advances the phase, wrapping after the last one. The error rate and the time-out never move rate or phase.
- R11: In manual mode, `lock_o` takes the value of `sync_i` at each window end, whatever the error rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_stb_i | input | 1 | One decoded bit this cycle |
| err_stb_i | input | 1 | The decoded bit was in error (qualified by bit_stb_i) |
| sync_i | input | 1 | Block sync found by the downstream framer |
| mode_am_i | input | 1 | 1 selects manual mode |
| mode_f_i | input | 1 | Freeze in automatic mode; phase step edge in manual mode |
| std_alt_i | input | 1 | Highest rate is 6/7 instead of 7/8 |
| rate_en_i | input | 5 | Enable per rate index |
| thr_i | input | 35 | Seven-bit threshold per rate, rate k at bits 7k+6..7k |
| hyst_i | input | 7 | Hysteresis added to the threshold while locked |
| timeout_i | input | 8 | Sync time-out in windows |
| rate_o | output | 3 | Current rate index |
| phase_o | output | 3 | Current puncture phase |
| err_rate_o | output | 8 | Errors in the last completed window |
| lock_o | output | 1 | Lock flag |

## Verification
The phase-range assertion assumes that `std_alt_i` changes only while the rate under trial is not the highest one. Otherwise a phase of 6 could briefly be out of range. The bench changes that select only while the search sits at rate 2. The manual-mode hold check assumes that `rate_en_i` is steady while in manual mode. The bench keeps error and sync stimulus aligned to window boundaries, and it holds `err_stb_i` high on cycles with no bit strobe, which must have no effect.

// File: rtl/pr_pkg.sv
package pr_pkg;
  localparam int NRATE  = 5;
  localparam int RATE_W = 3;
  localparam int PH_W   = 3;

  function automatic logic [PH_W-1:0] phase_count(logic [RATE_W-1:0] r, logic alt);
    case (r)
      3'd0:    phase_count = 3'd1;
      3'd1:    phase_count = 3'd2;
      3'd2:    phase_count = 3'd3;
      3'd3:    phase_count = 3'd5;
      3'd4:    phase_count = alt ? 3'd6 : 3'd7;
      default: phase_count = 3'd1;
    endcase
  endfunction

  // next enabled index after r, cyclic; r itself if it is the only one; r if none
  function automatic logic [RATE_W-1:0] next_enabled(logic [RATE_W-1:0] r, logic [NRATE-1:0] en);
    logic found;
    int idx;
    next_enabled = r;
    found = 1'b0;
    for (int k = 1; k <= NRATE; k++) begin
      idx = (int'(r) + k) % NRATE;
      if (!found && en[idx]) begin
        next_enabled = RATE_W'(idx);
        found = 1'b1;
      end
    end
  endfunction

  function automatic logic [RATE_W-1:0] lowest_enabled(logic [RATE_W-1:0] r, logic [NRATE-1:0] en);
    lowest_enabled = r;
    for (int k = NRATE - 1; k >= 0; k--) begin
      if (en[k]) lowest_enabled = RATE_W'(k);
    end
  endfunction
endpackage

// File: rtl/pr_err_window.sv
module pr_err_window #(
  parameter int WIN_LG = 8,
  parameter int ERR_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_stb_i,
  input  logic             err_stb_i,
  output logic [ERR_W-1:0] err_rate_o,
  output logic             done_o
);
  logic [WIN_LG-1:0] bit_cnt_q;
  logic [WIN_LG:0]   err_acc_q;
  logic [WIN_LG:0]   err_sum;
  logic              sat;

  assign err_sum = err_acc_q + (WIN_LG+1)'(err_stb_i);
  assign sat     = (err_sum > (WIN_LG+1)'({ERR_W{1'b1}}));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q  <= '0;
      err_acc_q  <= '0;
      err_rate_o <= '0;
      done_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (bit_stb_i) begin
        bit_cnt_q <= bit_cnt_q + 1'b1;
        if (&bit_cnt_q) begin
          err_rate_o <= sat ? {ERR_W{1'b1}} : ERR_W'(err_sum);
          err_acc_q  <= '0;
          done_o     <= 1'b1;
        end else begin
          err_acc_q <= err_sum;
        end
      end
    end
  end

  assert_rate_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(err_rate_o));
endmodule

// File: rtl/pr_lock_eval.sv
module pr_lock_eval #(
  parameter int ERR_W = 8,
  parameter int THR_W = 7,
  parameter int TMO_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             win_done_i,
  input  logic [ERR_W-1:0] err_rate_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic [THR_W-1:0] hyst_i,
  input  logic             sync_i,
  input  logic [TMO_W-1:0] timeout_i,
  input  logic             manual_i,
  input  logic             rate_ok_i,
  output logic             lock_o,
  output logic             step_o
);
  localparam int CW = (ERR_W > THR_W ? ERR_W : THR_W) + 1;

  logic [CW-1:0]    err_x, thr_x, lim_x;
  logic [TMO_W-1:0] tmo_q, tmo_d, tmo_nxt;
  logic             lock_d;

  assign err_x   = CW'(err_rate_i);
  assign thr_x   = CW'(thr_i);
  assign lim_x   = thr_x + CW'(hyst_i);
  assign tmo_nxt = tmo_q + 1'b1;

  always_comb begin
    step_o = 1'b0;
    lock_d = lock_o;
    tmo_d  = tmo_q;
    if (win_done_i) begin
      tmo_d = '0;
      if (manual_i) begin
        lock_d = sync_i;
      end else if (!rate_ok_i) begin
        step_o = 1'b1;
        lock_d = 1'b0;
      end else if (lock_o) begin
        if (err_x > lim_x || !sync_i) lock_d = 1'b0;
      end else if (err_x > thr_x) begin
        step_o = 1'b1;
      end else if (sync_i) begin
        lock_d = 1'b1;
      end else if (tmo_nxt >= timeout_i) begin
        step_o = 1'b1;
      end else begin
        tmo_d = tmo_nxt;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_o <= 1'b0;
      tmo_q  <= '0;
    end else begin
      lock_o <= lock_d;
      tmo_q  <= tmo_d;
    end
  end

  assert_lock_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(win_done_i && sync_i));

  assert_lock_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && !win_done_i) |=> lock_o);

  assert_manual_lock_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (manual_i && win_done_i) |=> (lock_o == $past(sync_i)));
endmodule

// File: rtl/pr_rate_phase.sv
module pr_rate_phase
  import pr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              manual_i,
  input  logic              frozen_i,
  input  logic              f_i,
  input  logic              alt_i,
  input  logic [NRATE-1:0]  rate_en_i,
  output logic [RATE_W-1:0] rate_o,
  output logic [PH_W-1:0]   phase_o,
  output logic              rate_ok_o
);
  logic                f_q, f_rise, last_ph;
  logic [RATE_W-1:0]   forced, nxt_rate;
  logic [PH_W-1:0]     np_cur;

  assign f_rise    = f_i && !f_q;
  assign np_cur    = phase_count(rate_o, alt_i);
  assign last_ph   = (phase_o >= np_cur - 1'b1);
  assign forced    = lowest_enabled(rate_o, rate_en_i);
  assign nxt_rate  = next_enabled(rate_o, rate_en_i);
  assign rate_ok_o = rate_en_i[rate_o];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_o  <= '0;
      phase_o <= '0;
      f_q     <= 1'b0;
    end else begin
      f_q <= f_i;
      if (manual_i) begin
        if (forced != rate_o) begin
          rate_o  <= forced;
          phase_o <= (phase_o < phase_count(forced, alt_i)) ? phase_o : '0;
        end else if (f_rise) begin
          phase_o <= last_ph ? '0 : phase_o + 1'b1;
        end
      end else if (step_i) begin
        if (!rate_ok_o) begin
          rate_o  <= nxt_rate;
          phase_o <= '0;
        end else if (!last_ph) begin
          phase_o <= phase_o + 1'b1;
        end else begin
          phase_o <= '0;
          if (!frozen_i) rate_o <= nxt_rate;
        end
      end
    end
  end

  assert_phase_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o < np_cur);

  assert_hold_no_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!manual_i && !step_i) |=> ($stable(rate_o) && $stable(phase_o)));

  assert_frozen_rate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frozen_i && !manual_i && rate_ok_o) |=> $stable(rate_o));

  assert_manual_phase_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (manual_i && !f_rise && forced == rate_o) |=> $stable(phase_o));
endmodule

// File: rtl/punct_search.sv
module punct_search
  import pr_pkg::*;
#(
  parameter int WIN_LG = 8,
  parameter int ERR_W  = 8,
  parameter int THR_W  = 7,
  parameter int TMO_W  = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   bit_stb_i,
  input  logic                   err_stb_i,
  input  logic                   sync_i,
  input  logic                   mode_am_i,
  input  logic                   mode_f_i,
  input  logic                   std_alt_i,
  input  logic [NRATE-1:0]       rate_en_i,
  input  logic [NRATE*THR_W-1:0] thr_i,
  input  logic [THR_W-1:0]       hyst_i,
  input  logic [TMO_W-1:0]       timeout_i,
  output logic [RATE_W-1:0]      rate_o,
  output logic [PH_W-1:0]        phase_o,
  output logic [ERR_W-1:0]       err_rate_o,
  output logic                   lock_o
);
  logic [THR_W-1:0] thr_arr [NRATE];
  logic [THR_W-1:0] thr_sel;
  logic             win_done, step, rate_ok, frozen;

  for (genvar k = 0; k < NRATE; k++) begin : g_thr
    assign thr_arr[k] = thr_i[k*THR_W +: THR_W];
  end

  always_comb begin
    thr_sel = '0;
    for (int k = 0; k < NRATE; k++) begin
      if (int'(rate_o) == k) thr_sel = thr_arr[k];
    end
  end

  assign frozen = !mode_am_i && mode_f_i;

  pr_err_window #(.WIN_LG(WIN_LG), .ERR_W(ERR_W)) i_win (
    .clk_i, .rst_ni,
    .bit_stb_i, .err_stb_i,
    .err_rate_o,
    .done_o (win_done)
  );

  pr_lock_eval #(.ERR_W(ERR_W), .THR_W(THR_W), .TMO_W(TMO_W)) i_lock (
    .clk_i, .rst_ni,
    .win_done_i (win_done),
    .err_rate_i (err_rate_o),
    .thr_i      (thr_sel),
    .hyst_i,
    .sync_i,
    .timeout_i,
    .manual_i   (mode_am_i),
    .rate_ok_i  (rate_ok),
    .lock_o,
    .step_o     (step)
  );

  pr_rate_phase i_rp (
    .clk_i, .rst_ni,
    .step_i    (step),
    .manual_i  (mode_am_i),
    .frozen_i  (frozen),
    .f_i       (mode_f_i),
    .alt_i     (std_alt_i),
    .rate_en_i,
    .rate_o,
    .phase_o,
    .rate_ok_o (rate_ok)
  );
endmodule

// File: tb/test_punct_search.sv
module test_punct_search;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_stb = 1'b0, err_stb = 1'b0, sync = 1'b0;
  logic        am = 1'b0, f = 1'b0, alt = 1'b0;
  logic [4:0]  rate_en = 5'b11111;
  logic [34:0] thr = {5{7'd20}};
  logic [6:0]  hyst = 7'd10;
  logic [7:0]  timeout = 8'd3;
  logic [2:0]  rate, phase;
  logic [7:0]  err_rate;
  logic        lock;
  int          n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  punct_search i_punct_search (
    .clk_i(clk), .rst_ni(rst_n), .bit_stb_i(bit_stb), .err_stb_i(err_stb),
    .sync_i(sync), .mode_am_i(am), .mode_f_i(f), .std_alt_i(alt),
    .rate_en_i(rate_en), .thr_i(thr), .hyst_i(hyst), .timeout_i(timeout),
    .rate_o(rate), .phase_o(phase), .err_rate_o(err_rate), .lock_o(lock)
  );

  // row table: errors in window, sync, expected rate, phase, lock
  localparam int NV = 12;
  localparam int V_ERR  [NV] = '{50, 50, 50, 10, 10, 10, 10, 25, 30, 31, 256, 0};
  localparam int V_SYNC [NV] = '{0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 1, 1};
  localparam int V_RATE [NV] = '{1, 1, 2, 2, 2, 2, 2, 2, 2, 2, 2, 2};
  localparam int V_PH   [NV] = '{0, 1, 0, 0, 0, 1, 1, 1, 1, 1, 2, 2};
  localparam int V_LOCK [NV] = '{0, 0, 0, 0, 0, 0, 1, 1, 1, 0, 0, 1};

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // 256 bit strobes, first nerr in error; err_stb high on idle cycles must not count (R1)
  task automatic send_window(int nerr, logic s);
    sync = s;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      bit_stb = 1'b1;
      err_stb = (i < nerr);
      @(negedge clk);
      bit_stb = 1'b0;
      err_stb = 1'b1;
    end
    @(negedge clk);
    err_stb = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic bad_windows(int n);
    for (int i = 0; i < n; i++) send_window(60, 1'b0);
  endtask

  task automatic f_pulse();
    @(negedge clk); f = 1'b0;
    @(negedge clk); f = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=1 expected=0");
    finish_run();
  end

  initial begin
    do_reset();
    // R2 reset state
    chk("R2", "rate", int'(rate), 0);
    chk("R2", "phase", int'(phase), 0);
    chk("R2", "lock", int'(lock), 0);
    chk("R2", "err_rate", int'(err_rate), 0);

    // automatic search, thresholds 20, hysteresis 10, time-out 3
    for (int v = 0; v < NV; v++) begin
      send_window(V_ERR[v], V_SYNC[v] != 0);
      chk("R1", "err_rate", int'(err_rate), (V_ERR[v] > 255) ? 255 : V_ERR[v]);
      chk("R3/R6", "rate", int'(rate), V_RATE[v]);
      chk("R3/R6", "phase", int'(phase), V_PH[v]);
      chk("R7/R8", "lock", int'(lock), V_LOCK[v]);
    end
    // R1 hold between windows
    repeat (40) @(negedge clk);
    chk("R1", "err_rate held", int'(err_rate), 0);

    // R5 disabled rates skipped, R4 six phases at rate 4 with alt select
    rate_en = 5'b10100;
    alt = 1'b1;
    do_reset();
    send_window(0, 1'b1);
    chk("R5", "jump rate", int'(rate), 2);
    chk("R5", "jump phase", int'(phase), 0);
    chk("R5", "no lock on jump", int'(lock), 0);
    bad_windows(3);
    chk("R3", "skip to rate 4", int'(rate), 4);
    chk("R3", "phase 0", int'(phase), 0);
    bad_windows(5);
    chk("R4", "alt last phase", int'(phase), 5);
    bad_windows(1);
    chk("R4", "alt wrap rate", int'(rate), 2);
    chk("R4", "alt wrap phase", int'(phase), 0);

    // R9 frozen mode
    f = 1'b1;
    bad_windows(2);
    chk("R9", "frozen phase", int'(phase), 2);
    bad_windows(1);
    chk("R9", "frozen rate", int'(rate), 2);
    chk("R9", "frozen wrap", int'(phase), 0);
    f = 1'b0;

    // R4 seven phases without alt select
    alt = 1'b0;
    bad_windows(3);
    chk("R4", "rate 4", int'(rate), 4);
    bad_windows(6);
    chk("R4", "last phase 7/8", int'(phase), 6);
    chk("R4", "still rate 4", int'(rate), 4);
    bad_windows(1);
    chk("R4", "wrap rate", int'(rate), 2);

    // R10 manual mode
    rate_en = 5'b01000;
    am = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10", "forced rate", int'(rate), 3);
    chk("R10", "kept phase", int'(phase), 0);
    f_pulse();
    chk("R10", "edge step", int'(phase), 1);
    send_window(100, 1'b1);
    chk("R10", "errors ignored", int'(phase), 1);
    chk("R11", "lock from sync", int'(lock), 1);
    chk("R11", "err_rate shown", int'(err_rate), 100);
    for (int i = 0; i < 4; i++) send_window(0, 1'b0);
    chk("R10", "time-out ignored", int'(phase), 1);
    chk("R11", "lock dropped", int'(lock), 0);
    f_pulse(); f_pulse(); f_pulse();
    chk("R10", "phase 4", int'(phase), 4);
    f_pulse();
    chk("R10", "manual wrap", int'(phase), 0);
    chk("R10", "rate kept", int'(rate), 3);

    finish_run();
  end
endmodule